// File: doc/BRIEF.md
# Equalizer Boost Adaptation Controller

This controller finds a good high-frequency boost setting for a receive equalizer. It walks an ordered table of candidate boost codes. Each entry is meant to give more boost than the one before it. For each candidate it drives the code onto the boost bus and asks an external clock-recovery loop to lock. Only when the lock attempt succeeds does it ask an external eye monitor for a horizontal and a vertical opening. The product of the two openings is the figure of merit. The controller keeps the candidate with the highest figure of merit seen so far.

The search does not give up at the first worse candidate. It keeps a count of trials that fail to beat the best. Once that count goes past a look-beyond budget, it stops and drives the best code again. The search also stops when the table runs out. The chosen code is kept in a result register. A fail flag reports a run in which no candidate ever locked.

The candidate table can be rewritten between runs. A channel reset puts it back to its built-in values.

The two requests work as valid/ready-style handshakes. Each request is a level that stays high until the matching acknowledge arrives. The acknowledge carries the reply data in the same cycle. The block applies no back-pressure: while it waits, it takes the first acknowledge. An acknowledge outside a wait is dropped.

Top module: `eq_adapt_ctrl`

## Requirements
- R1: After `rst_n` is released, `boost_out`, `result`, `done`, `fail`, `lock_req`, `eye_req` and `busy` are all zero.
- R2: A `start` seen while idle makes the block busy in the next cycle. In that cycle it drives table entry 0 on `boost_out` and raises `lock_req`. Candidates then follow in table index order, and `lock_req` stays high until a `lock_ack` arrives.
- R3: `eye_req` rises only in the cycle after a `lock_ack` with `lock_ok`=1, and it stays high until `eye_ack`. `lock_req` and `eye_req` are never high together.
- R4: The figure of merit is the unsigned product `eye_h`*`eye_v`. The first locked candidate always becomes the best. After that, only a strictly greater product replaces the best, so ties and smaller values count as misses.
- R5: A new best clears the miss count. After a miss, the search ends once the misses since the last best exceed `look_beyond`. `look_beyond` is sampled at `start`, so a value of 0 stops at the first miss.
- R6: A lock attempt answered with `lock_ok`=0 is a miss, and no eye request is made for that candidate.
- R7: After the last table entry has been judged, the search ends whatever the miss count.
- R8: When a search ends, one cycle passes and then `done` pulses for exactly one cycle. In that cycle `busy` is low and `boost_out` equals `result`, which holds the best candidate's table value. `result` changes only with `done`.
- R9: If no candidate locked, the block drives table entry 0 and sets `fail` together with `done`. `fail` stays set until the next accepted `start`.
- R10: A table write (`tbl_wr_en`, `tbl_wr_addr`, `tbl_wr_data`) is used by later runs. `chan_rst` or `rst_n` sets every entry i back to i*(2^BOOST_W/NUM_CAND), and `chan_rst` wins over a write in the same cycle.
- R11: A `start` while busy, and a `lock_ack` or `eye_ack` while idle, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Synchronous restore of the candidate table defaults |
| start | input | 1 | Begin an adaptation run when idle |
| look_beyond | input | LB_W (4) | Number of misses allowed after the last best |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| fail | output | 1 | No candidate locked in the last run |
| boost_out | output | BOOST_W (8) | Boost code applied to the equalizer |
| result | output | BOOST_W (8) | Chosen boost code of the last run |
| lock_req | output | 1 | Lock attempt request, held until acknowledged |
| lock_ack | input | 1 | Lock attempt finished |
| lock_ok | input | 1 | Lock attempt succeeded (valid with lock_ack) |
| eye_req | output | 1 | Eye measurement request, held until acknowledged |
| eye_ack | input | 1 | Eye measurement finished |
| eye_h | input | EYE_W (8) | Horizontal opening (valid with eye_ack) |
| eye_v | input | EYE_W (8) | Vertical opening (valid with eye_ack) |
| tbl_wr_en | input | 1 | Candidate table write strobe |
| tbl_wr_addr | input | IDX_W (4) | Candidate table write index |
| tbl_wr_data | input | BOOST_W (8) | Candidate table write value |

## Verification
The assertions assume the external lock and eye models answer only while their request is high, with one acknowledge pulse per request. They also assume reply data is valid in the acknowledge cycle. The bench models both responders this way, with fixed latencies and replies keyed on the boost code being driven. The one exception is a deliberate burst of stray acknowledges sent while the block is idle. The request-hold and idle properties cover that burst. The bench writes the table and pulses the channel reset only between runs, so a run never sees its candidates change under it.

// File: rtl/eqa_pkg.sv
package eqa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOCK = 2'd1,
    ST_EYE  = 2'd2,
    ST_FIN  = 2'd3
  } eqa_state_e;

endpackage

// File: rtl/eqa_cand_table.sv
module eqa_cand_table #(
  parameter int NUM_CAND = 16,
  parameter int BOOST_W  = 8,
  parameter int IDX_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_addr,
  input  logic [BOOST_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_addr,
  output logic [BOOST_W-1:0] rd_data
);

  localparam int STEP = (1 << BOOST_W) / NUM_CAND;

  logic [NUM_CAND-1:0][BOOST_W-1:0] ents;

  for (genvar g = 0; g < NUM_CAND; g++) begin : g_ent
    localparam logic [BOOST_W-1:0] DEF = BOOST_W'(g * STEP);
    logic [BOOST_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= DEF;
      else if (chan_rst)
        q <= DEF;
      else if (wr_en && (wr_addr == IDX_W'(g)))
        q <= wr_data;
    end
    assign ents[g] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_CAND; k++)
      if (rd_addr == IDX_W'(k))
        rd_data = ents[k];
  end

endmodule

// File: rtl/eqa_fom.sv
module eqa_fom #(
  parameter int EYE_W = 8,
  parameter int FOM_W = 2 * EYE_W
) (
  input  logic [EYE_W-1:0] eye_h,
  input  logic [EYE_W-1:0] eye_v,
  input  logic [FOM_W-1:0] best_fom,
  input  logic             best_valid,
  output logic [FOM_W-1:0] fom,
  output logic             better
);

  always_comb begin
    fom    = FOM_W'(eye_h) * FOM_W'(eye_v);
    better = !best_valid || (fom > best_fom);
  end

endmodule

// File: rtl/eqa_seq.sv
module eqa_seq
  import eqa_pkg::*;
#(
  parameter int NUM_CAND = 16,
  parameter int BOOST_W  = 8,
  parameter int LB_W     = 4,
  parameter int IDX_W    = 4,
  parameter int FOM_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LB_W-1:0]    look_beyond,
  input  logic               lock_ack,
  input  logic               lock_ok,
  input  logic               eye_ack,
  input  logic               better,
  input  logic [FOM_W-1:0]   fom,
  output logic [FOM_W-1:0]   best_fom,
  output logic               best_valid,
  output logic [IDX_W-1:0]   rd_addr,
  input  logic [BOOST_W-1:0] rd_data,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [BOOST_W-1:0] boost_out,
  output logic [BOOST_W-1:0] result,
  output logic               lock_req,
  output logic               eye_req
);

  localparam int MISS_W = LB_W + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CAND - 1);

  eqa_state_e          state;
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    best_idx;
  logic [MISS_W-1:0]   miss;
  logic [LB_W-1:0]     lb_q;
  logic [BOOST_W-1:0]  boost_q;
  logic [BOOST_W-1:0]  result_q;
  logic                done_q;
  logic                fail_q;

  logic                trial;
  logic                imp;
  logic                stop;
  logic [MISS_W-1:0]   miss_nx;

  always_comb begin
    trial   = ((state == ST_LOCK) && lock_ack && !lock_ok) ||
              ((state == ST_EYE) && eye_ack);
    imp     = (state == ST_EYE) && better;
    miss_nx = miss + MISS_W'(1);
    stop    = (!imp && (miss_nx > {1'b0, lb_q})) || (idx == LAST);
    case (state)
      ST_IDLE: rd_addr = '0;
      ST_FIN:  rd_addr = best_valid ? best_idx : '0;
      default: rd_addr = idx + IDX_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      best_idx   <= '0;
      best_fom   <= '0;
      best_valid <= 1'b0;
      miss       <= '0;
      lb_q       <= '0;
      boost_q    <= '0;
      result_q   <= '0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            idx        <= '0;
            best_idx   <= '0;
            best_fom   <= '0;
            best_valid <= 1'b0;
            miss       <= '0;
            lb_q       <= look_beyond;
            fail_q     <= 1'b0;
            boost_q    <= rd_data;
            state      <= ST_LOCK;
          end
        end
        ST_LOCK: begin
          if (lock_ack && lock_ok)
            state <= ST_EYE;
        end
        ST_FIN: begin
          boost_q  <= rd_data;
          result_q <= rd_data;
          fail_q   <= !best_valid;
          done_q   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: ;
      endcase

      if (trial) begin
        if (imp) begin
          best_fom   <= fom;
          best_idx   <= idx;
          best_valid <= 1'b1;
          miss       <= '0;
        end else begin
          miss <= miss_nx;
        end
        if (stop) begin
          state <= ST_FIN;
        end else begin
          idx     <= idx + IDX_W'(1);
          boost_q <= rd_data;
          state   <= ST_LOCK;
        end
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign lock_req  = (state == ST_LOCK);
  assign eye_req   = (state == ST_EYE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign boost_out = boost_q;
  assign result    = result_q;

endmodule

// File: rtl/eq_adapt_ctrl.sv
module eq_adapt_ctrl #(
  parameter int NUM_CAND = 16,
  parameter int BOOST_W  = 8,
  parameter int EYE_W    = 8,
  parameter int LB_W     = 4,
  parameter int IDX_W    = $clog2(NUM_CAND)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_rst,
  input  logic               start,
  input  logic [LB_W-1:0]    look_beyond,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [BOOST_W-1:0] boost_out,
  output logic [BOOST_W-1:0] result,
  output logic               lock_req,
  input  logic               lock_ack,
  input  logic               lock_ok,
  output logic               eye_req,
  input  logic               eye_ack,
  input  logic [EYE_W-1:0]   eye_h,
  input  logic [EYE_W-1:0]   eye_v,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_addr,
  input  logic [BOOST_W-1:0] tbl_wr_data
);

  localparam int FOM_W = 2 * EYE_W;

  logic [IDX_W-1:0]   rd_addr;
  logic [BOOST_W-1:0] rd_data;
  logic [FOM_W-1:0]   fom;
  logic [FOM_W-1:0]   best_fom;
  logic               best_valid;
  logic               better;

  eqa_cand_table #(
    .NUM_CAND (NUM_CAND),
    .BOOST_W  (BOOST_W),
    .IDX_W    (IDX_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_rst (chan_rst),
    .wr_en    (tbl_wr_en),
    .wr_addr  (tbl_wr_addr),
    .wr_data  (tbl_wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  eqa_fom #(
    .EYE_W (EYE_W),
    .FOM_W (FOM_W)
  ) u_fom (
    .eye_h      (eye_h),
    .eye_v      (eye_v),
    .best_fom   (best_fom),
    .best_valid (best_valid),
    .fom        (fom),
    .better     (better)
  );

  eqa_seq #(
    .NUM_CAND (NUM_CAND),
    .BOOST_W  (BOOST_W),
    .LB_W     (LB_W),
    .IDX_W    (IDX_W),
    .FOM_W    (FOM_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .look_beyond (look_beyond),
    .lock_ack    (lock_ack),
    .lock_ok     (lock_ok),
    .eye_ack     (eye_ack),
    .better      (better),
    .fom         (fom),
    .best_fom    (best_fom),
    .best_valid  (best_valid),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .busy        (busy),
    .done        (done),
    .fail        (fail),
    .boost_out   (boost_out),
    .result      (result),
    .lock_req    (lock_req),
    .eye_req     (eye_req)
  );

endmodule

// File: rtl/eqa_chk.sv
module eqa_chk #(
  parameter int BOOST_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic [BOOST_W-1:0] boost_out,
  input logic [BOOST_W-1:0] result,
  input logic               lock_req,
  input logic               lock_ack,
  input logic               lock_ok,
  input logic               eye_req,
  input logic               eye_ack
);

  AST_START_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && lock_req)); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_req && !lock_ack) |=> lock_req); // R2
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_req && eye_req)); // R3
  AST_EYE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eye_req) |-> $past(lock_ack && lock_ok)); // R3
  AST_EYE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eye_req && !eye_ack) |=> eye_req); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && (boost_out == result))); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result)); // R8
  AST_FAIL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy); // R11

endmodule

bind eq_adapt_ctrl eqa_chk #(.BOOST_W(BOOST_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .boost_out (boost_out),
  .result    (result),
  .lock_req  (lock_req),
  .lock_ack  (lock_ack),
  .lock_ok   (lock_ok),
  .eye_req   (eye_req),
  .eye_ack   (eye_ack)
);

// File: tb/eq_adapt_ctrl_test.sv
module eq_adapt_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NC   = 16;
  localparam int BW   = 8;
  localparam int EW   = 8;
  localparam int LBW  = 4;
  localparam int IW   = 4;
  localparam int STEP = 256 / NC;
  localparam int LOCK_LAT = 3;
  localparam int EYE_LAT  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chan_rst = 1'b0;
  logic          start = 1'b0;
  logic [LBW-1:0] look_beyond = '0;
  logic          busy, done, fail, lock_req, eye_req;
  logic [BW-1:0] boost_out, result;
  logic          lock_ack = 1'b0, lock_ok = 1'b0, eye_ack = 1'b0;
  logic [EW-1:0] eye_h = '0, eye_v = '0;
  logic          tbl_wr_en = 1'b0;
  logic [IW-1:0] tbl_wr_addr = '0;
  logic [BW-1:0] tbl_wr_data = '0;

  int total = 0;
  int bad = 0;
  int inject = 0;
  int lk_of [256];
  int h_of  [256];
  int v_of  [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  eq_adapt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst), .start(start),
    .look_beyond(look_beyond), .busy(busy), .done(done), .fail(fail),
    .boost_out(boost_out), .result(result), .lock_req(lock_req),
    .lock_ack(lock_ack), .lock_ok(lock_ok), .eye_req(eye_req),
    .eye_ack(eye_ack), .eye_h(eye_h), .eye_v(eye_v),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_st = 0, m_idx = 0, m_bi = 0, m_bf = 0, m_bv = 0, m_miss = 0, m_lb = 0;
  int m_boost = 0, m_done = 0, m_fail = 0, m_res = 0;
  int m_tbl [NC];
  initial for (int i = 0; i < NC; i++) m_tbl[i] = i * STEP;

  always @(posedge clk or negedge rst_n) begin
    int tr, imp, f, sel, stp;
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_bi = 0; m_bf = 0; m_bv = 0; m_miss = 0; m_lb = 0;
      m_boost = 0; m_done = 0; m_fail = 0; m_res = 0;
      for (int i = 0; i < NC; i++) m_tbl[i] = i * STEP;
    end else begin
      tr = 0; imp = 0; f = 0;
      m_done = 0;
      if (m_st == 0) begin
        if (start) begin
          m_idx = 0; m_bv = 0; m_bf = 0; m_bi = 0; m_miss = 0;
          m_lb = int'(look_beyond); m_fail = 0; m_boost = m_tbl[0]; m_st = 1;
        end
      end else if (m_st == 1) begin
        if (lock_ack) begin
          if (lock_ok) m_st = 2;
          else tr = 1;
        end
      end else if (m_st == 2) begin
        if (eye_ack) begin
          tr = 1;
          f = int'(eye_h) * int'(eye_v);
          imp = (m_bv == 0) || (f > m_bf);
        end
      end else begin
        sel = (m_bv != 0) ? m_tbl[m_bi] : m_tbl[0];
        m_boost = sel; m_res = sel; m_fail = (m_bv == 0); m_done = 1; m_st = 0;
      end
      if (tr != 0) begin
        if (imp != 0) begin
          m_bf = f; m_bi = m_idx; m_bv = 1; m_miss = 0;
        end else begin
          m_miss++;
        end
        stp = ((imp == 0) && (m_miss > m_lb)) || (m_idx == NC - 1);
        if (stp != 0) m_st = 3;
        else begin
          m_idx++; m_boost = m_tbl[m_idx]; m_st = 1;
        end
      end
      if (chan_rst) for (int i = 0; i < NC; i++) m_tbl[i] = i * STEP;
      else if (tbl_wr_en) m_tbl[tbl_wr_addr] = int'(tbl_wr_data);
    end
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2",  "boost_out", int'(boost_out), m_boost);
      check("R2",  "lock_req",  int'(lock_req), int'(m_st == 1));
      check("R3",  "eye_req",   int'(eye_req), int'(m_st == 2));
      check("R11", "busy",      int'(busy), int'(m_st != 0));
      check("R8",  "done",      int'(done), m_done);
      check("R8",  "result",    int'(result), m_res);
      check("R9",  "fail",      int'(fail), m_fail);
    end
  end

  // External lock loop and eye monitor models
  int lc = 0, ec = 0;
  always @(negedge clk) begin
    if (inject != 0) begin
      lock_ack <= 1'b1; lock_ok <= 1'b1; eye_ack <= 1'b1;
      eye_h <= 8'd200; eye_v <= 8'd200;
    end else begin
      lock_ack <= 1'b0;
      eye_ack  <= 1'b0;
      if (lock_req && !lock_ack) begin
        lc++;
        if (lc >= LOCK_LAT) begin
          lock_ack <= 1'b1; lock_ok <= (lk_of[boost_out] != 0); lc = 0;
        end
      end else lc = 0;
      if (eye_req && !eye_ack) begin
        ec++;
        if (ec >= EYE_LAT) begin
          eye_ack <= 1'b1;
          eye_h <= EW'(h_of[boost_out]);
          eye_v <= EW'(v_of[boost_out]);
          ec = 0;
        end
      end else ec = 0;
    end
  end

  task automatic prof(input int i, input int lk, input int h, input int v);
    lk_of[m_tbl[i]] = lk; h_of[m_tbl[i]] = h; v_of[m_tbl[i]] = v;
  endtask

  task automatic prof_peak5();
    for (int i = 0; i < NC; i++)
      prof(i, 1, (i <= 5) ? (i + 1) * 10 : 60 - (i - 5) * 5, 20);
  endtask

  task automatic run(input int lb, input bit poke);
    @(negedge clk);
    look_beyond = LBW'(lb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      start = (poke && k == 4) ? 1'b1 : 1'b0;
      @(negedge clk);
      if (done) break;
    end
    start = 1'b0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = IW'(a); tbl_wr_data = BW'(d);
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin lk_of[i] = 0; h_of[i] = 0; v_of[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset boost_out", int'(boost_out), 0);
    check("R1", "reset result", int'(result), 0);
    check("R1", "reset flags", int'({done, fail, busy, lock_req, eye_req}), 0);

    // R5 peak at index 5, look-beyond 2
    prof_peak5();
    run(2, 1'b0);
    check("R5", "peak lb2 result", int'(result), 80);
    check("R5", "peak lb2 fail", int'(fail), 0);

    // R5 look-beyond 0 stops at first drop
    run(0, 1'b0);
    check("R5", "peak lb0 result", int'(result), 80);

    // R4 ties are not improvements
    for (int i = 0; i < NC; i++) prof(i, 1, 10, 10);
    prof(0, 1, 10, 20); prof(1, 1, 20, 20); prof(2, 1, 30, 20);
    prof(3, 1, 40, 20); prof(4, 1, 20, 40); prof(5, 1, 80, 10);
    run(2, 1'b0);
    check("R4", "tie result", int'(result), 48);

    // R4 product, not a single axis, decides
    prof(0, 1, 100, 10); prof(1, 1, 50, 30); prof(2, 1, 200, 5);
    run(0, 1'b0);
    check("R4", "product result", int'(result), 16);

    // R6 failed locks count as misses
    for (int i = 0; i < NC; i++) prof(i, (i == 1 || i == 2) ? 0 : 1, 10 + i * 10, 20);
    run(1, 1'b0);
    check("R6", "lock-miss result", int'(result), 0);
    check("R6", "lock-miss fail", int'(fail), 0);

    // R7 exhaustion, with R11 start poke while busy
    run(2, 1'b1);
    check("R7", "exhaust result", int'(result), 240);

    // R11 stray acknowledges while idle
    @(negedge clk); inject = 1;
    repeat (3) @(negedge clk);
    inject = 0;
    repeat (2) @(negedge clk);
    check("R11", "stray ack busy", int'(busy), 0);
    check("R11", "stray ack boost", int'(boost_out), 240);

    // R10 table writes used by the next run
    wr(0, 8'h3C);
    wr(5, 8'hA5);
    prof_peak5();
    run(2, 1'b0);
    check("R10", "written result", int'(result), 165);

    // R9 no lock at all
    for (int i = 0; i < NC; i++) prof(i, 0, 0, 0);
    run(3, 1'b0);
    check("R9", "nolock result", int'(result), 60);
    check("R9", "nolock fail", int'(fail), 1);
    check("R9", "nolock boost", int'(boost_out), 60);

    // R9 fail clears on next start; R10 channel reset restores defaults
    @(negedge clk); chan_rst = 1'b1;
    tbl_wr_en = 1'b1; tbl_wr_addr = 4'd5; tbl_wr_data = 8'h77;
    @(negedge clk); chan_rst = 1'b0; tbl_wr_en = 1'b0;
    prof_peak5();
    run(2, 1'b0);
    check("R10", "restored result", int'(result), 80);
    check("R9", "fail cleared", int'(fail), 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule